// File: doc/BRIEF.md
# SDRAM burst column sequencer

This block sits inside a synchronous DRAM with two internal banks. It takes decoded commands (read, write, burst stop and mode load), each arriving with a bank select and a start column. From these it produces one column address per clock for the length of a burst, with the bank and the direction of that burst. For reads it also produces a data-valid strobe. The strobe follows each read column by the programmed read latency of one, two or three clocks.

A mode load sets three things: the burst length (1, 2, 4, 8 or a whole page), the address order (sequential or interleaved) and the read latency. A sequential burst wraps inside the aligned block of its length. An interleaved burst XORs the start column with the beat count. A whole-page burst runs around the full column range until a command stops it. Whole-page length is not allowed with interleaved order. If a mode load asks for it, the block raises an error flag and uses eight beats instead. A read or write command can replace a running burst on any clock. A stop command or a mode load ends the burst, but read strobes already in flight still come out.

The controller is a three-state machine. **ST_IDLE** means no burst. **ST_READ** means a read burst is issuing columns. **ST_WRITE** means a write burst is issuing columns. The transitions are:

- *start_read*: any state to ST_READ on a read command.
- *start_write*: any state to ST_WRITE on a write command.
- *stop*: ST_READ or ST_WRITE to ST_IDLE on a stop command or a mode load.
- *done*: ST_READ or ST_WRITE to ST_IDLE after the last beat of a burst that is not whole-page.
- *hold*: no change in any other case.

Top module: `sdram_burst_seq`

## Requirements
- R1: All outputs change only on the rising clock edge. After reset, col_valid, rd_valid and mode_err are 0. The mode after reset is burst length 1, sequential order, read latency 1.
- R2: When cmd_valid is 1, cmd_op selects the command: 00 read, 01 write, 10 stop, 11 mode load. A read or write sampled at an edge makes the next cycle show col_valid=1, col_addr=cmd_col and col_bank=cmd_bank. col_is_rd is 1 for a read and 0 for a write.
- R3: mode_len values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. col_valid stays high for exactly that many cycles and then falls.
- R4: When mode_ilv=0, beat c has address (start & ~(L-1)) | ((start + c) mod L). The burst therefore wraps inside its aligned block of L columns.
- R5: When mode_ilv=1, beat c has address start XOR c.
- R6: mode_len values 4 to 7, with sequential order, select a whole-page burst. Its address rises by one each cycle, wraps from 1023 to 0, and continues until a command ends it.
- R7: A mode load with mode_ilv=1 and mode_len of 4 or more sets mode_err to 1 and gives 8-beat interleaved bursts. The next legal mode load clears mode_err.
- R8: A stop command or a mode load sampled at an edge makes col_valid 0 from the next cycle.
- R9: A read or write on any cycle of a running burst replaces that burst. The next cycle shows the new start column, bank and direction, followed by a full burst of the new command.
- R10: Each read beat produces one rd_valid pulse, lat cycles after the cycle in which that beat's column is shown. A read command therefore gives its first rd_valid lat cycles after the command's edge. mode_lat takes the values 1 to 3, and 0 is treated as 1. Write bursts give no rd_valid.
- R11: When a read burst is stopped, the rd_valid pulses for the read columns already issued are still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything acts on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Command code: 00 read, 01 write, 10 stop, 11 mode load |
| cmd_bank | input | BANK_W | Bank selected by a read or write |
| cmd_col | input | COL_W | Start column of a read or write |
| mode_len | input | 3 | Burst length code, sampled on mode load |
| mode_ilv | input | 1 | 1 selects interleaved order, sampled on mode load |
| mode_lat | input | 2 | Read latency code, sampled on mode load |
| col_valid | output | 1 | A column is being issued this cycle |
| col_is_rd | output | 1 | The issued column belongs to a read |
| col_bank | output | BANK_W | Bank of the current burst |
| col_addr | output | COL_W | Column address of this beat |
| rd_valid | output | 1 | Read data valid strobe |
| mode_err | output | 1 | The last mode load asked for an illegal combination |

## Verification
A wrong state register shows at the ports in the very next cycle. It either leaves col_valid high after a stop or at the end of a burst, or it flips col_is_rd away from the direction of the last command. A wrong beat counter or length decode shows as a wrong col_addr on the beat after the fault, or as a burst whose length is off by at least one beat. A fault in the latency pipeline appears within three cycles, as an rd_valid pulse that is early, late or missing compared with the read columns that were issued.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    // Width of the read latency code and the deepest latency it can select.
    localparam int LAT_W   = 2;
    localparam int MAX_LAT = (1 << LAT_W) - 1;

    // Decoded command codes on cmd_op.
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_STOP  = 2'b10,
        OP_MODE  = 2'b11
    } burst_op_e;

    // Controller states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } burst_state_e;

    // Mode settings after legalisation.
    typedef struct packed {
        logic             page;     // whole-page sequential burst
        logic [1:0]       len_log;  // log2 of the burst length when not whole-page
        logic             ilv;      // interleaved order
        logic [LAT_W-1:0] lat;      // read latency, 1..MAX_LAT
    } burst_mode_t;

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import sdram_burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [2:0]       len_code,
    input  logic             ilv_in,
    input  logic [LAT_W-1:0] lat_code,
    output burst_mode_t      mode,
    output logic             err
);

    logic             bad_combo;
    logic [LAT_W-1:0] lat_legal;

    // Whole-page length is not allowed with interleaved order.
    always_comb begin
        bad_combo = ilv_in & len_code[2];
        lat_legal = (lat_code == '0) ? LAT_W'(1) : lat_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode.page    <= 1'b0;
            mode.len_log <= 2'd0;
            mode.ilv     <= 1'b0;
            mode.lat     <= LAT_W'(1);
            err          <= 1'b0;
        end else if (load) begin
            mode.page    <= len_code[2] & ~ilv_in;
            mode.len_log <= bad_combo ? 2'd3 : len_code[1:0];
            mode.ilv     <= ilv_in;
            mode.lat     <= lat_legal;
            err          <= bad_combo;
        end
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] count,
    input  burst_mode_t      mode,
    output logic [COL_W-1:0] col,
    output logic             last
);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] sum;

    always_comb begin
        mask = (COL_W'(1) << mode.len_log) - COL_W'(1);
        sum  = start + count;
        if (mode.page) begin
            col = sum;
        end else if (mode.ilv) begin
            col = start ^ (count & mask);
        end else begin
            col = (start & ~mask) | (sum & mask);
        end
        last = !mode.page && ((count & mask) == mask);
    end

endmodule

// File: rtl/rd_valid_pipe.sv
module rd_valid_pipe
    import sdram_burst_pkg::*;
#(
    parameter int DEPTH = MAX_LAT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [LAT_W-1:0] lat,
    output logic             valid
);

    logic [DEPTH-1:0] stage;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                stage[i] <= stage[i-1];
            end
            stage[0] <= issue;
        end
    end

    // Pick the tap matching the latency.
    always_comb begin
        valid = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lat == LAT_W'(i + 1)) valid = stage[i];
        end
    end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_burst_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [2:0]        mode_len,
    input  logic              mode_ilv,
    input  logic [LAT_W-1:0]  mode_lat,
    output logic              col_valid,
    output logic              col_is_rd,
    output logic [BANK_W-1:0] col_bank,
    output logic [COL_W-1:0]  col_addr,
    output logic              rd_valid,
    output logic              mode_err
);

    burst_state_e      state_q, state_d;
    burst_op_e         op;
    burst_mode_t       mode_q;
    logic [COL_W-1:0]  start_q, cnt_q, gen_col;
    logic [BANK_W-1:0] bank_q;
    logic              is_rd, is_wr, is_stop, is_mode, last_beat, new_burst;
    logic              page_mode;

    always_comb begin
        op        = burst_op_e'(cmd_op);
        is_rd     = cmd_valid && (op == OP_READ);
        is_wr     = cmd_valid && (op == OP_WRITE);
        is_stop   = cmd_valid && (op == OP_STOP);
        is_mode   = cmd_valid && (op == OP_MODE);
        new_burst = is_rd || is_wr;
        page_mode = mode_q.page;
    end

    burst_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (is_mode),
        .len_code (mode_len),
        .ilv_in   (mode_ilv),
        .lat_code (mode_lat),
        .mode     (mode_q),
        .err      (mode_err)
    );

    burst_col_gen #(.COL_W(COL_W)) u_gen (
        .start (start_q),
        .count (cnt_q),
        .mode  (mode_q),
        .col   (gen_col),
        .last  (last_beat)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_rd)      state_d = ST_READ;   // start_read
                else if (is_wr) state_d = ST_WRITE;  // start_write
            end
            ST_READ, ST_WRITE: begin
                if (is_rd)                       state_d = ST_READ;
                else if (is_wr)                  state_d = ST_WRITE;
                else if (is_stop || is_mode)     state_d = ST_IDLE;  // stop
                else if (last_beat)              state_d = ST_IDLE;  // done
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Burst start, bank and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
            bank_q  <= '0;
        end else if (new_burst) begin
            start_q <= cmd_col;
            cnt_q   <= '0;
            bank_q  <= cmd_bank;
        end else if (state_q != ST_IDLE) begin
            cnt_q   <= cnt_q + COL_W'(1);
        end
    end

    // Outputs
    always_comb begin
        col_valid = (state_q != ST_IDLE);
        col_is_rd = (state_q == ST_READ);
        col_bank  = bank_q;
        col_addr  = gen_col;
    end

    rd_valid_pipe #(.DEPTH(MAX_LAT)) u_rdpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (col_valid && col_is_rd),
        .lat   (mode_q.lat),
        .valid (rd_valid)
    );

endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
    parameter int COL_W  = 10,
    parameter int BANK_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [COL_W-1:0]  cmd_col,
    input logic [2:0]        mode_len,
    input logic              mode_ilv,
    input logic              col_valid,
    input logic              col_is_rd,
    input logic [BANK_W-1:0] col_bank,
    input logic [COL_W-1:0]  col_addr,
    input logic              rd_valid,
    input logic              mode_err,
    input logic              page_mode
);

    assert_read_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b00) |=>
            (col_valid && col_is_rd && col_addr == $past(cmd_col) && col_bank == $past(cmd_bank)));

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b10) |=> !col_valid);

    assert_bad_mode_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b11 && mode_ilv && mode_len[2]) |=> mode_err);

    assert_page_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && page_mode && $past(col_valid) && !$past(cmd_valid)) |->
            (col_addr == COL_W'($past(col_addr) + COL_W'(1))));

    assert_rd_follows_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(col_valid && col_is_rd, 1) ||
                      $past(col_valid && col_is_rd, 2) ||
                      $past(col_valid && col_is_rd, 3)));

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W), .BANK_W(BANK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .cmd_col   (cmd_col),
    .mode_len  (mode_len),
    .mode_ilv  (mode_ilv),
    .col_valid (col_valid),
    .col_is_rd (col_is_rd),
    .col_bank  (col_bank),
    .col_addr  (col_addr),
    .rd_valid  (rd_valid),
    .mode_err  (mode_err),
    .page_mode (page_mode)
);

// File: tb/sdram_burst_seq_bench.sv
module sdram_burst_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic [0:0] cmd_bank;
    logic [9:0] cmd_col;
    logic [2:0] mode_len;
    logic       mode_ilv;
    logic [1:0] mode_lat;
    logic       col_valid, col_is_rd, rd_valid, mode_err;
    logic [0:0] col_bank;
    logic [9:0] col_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_seq u_sdram_burst_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .mode_len(mode_len),
        .mode_ilv(mode_ilv), .mode_lat(mode_lat), .col_valid(col_valid),
        .col_is_rd(col_is_rd), .col_bank(col_bank), .col_addr(col_addr),
        .rd_valid(rd_valid), .mode_err(mode_err)
    );

    // len, ilv, lat, rd, start, beats, last address
    typedef struct packed {
        logic [2:0] len;
        logic       ilv;
        logic [1:0] lat;
        logic       rd;
        logic [9:0] start;
        logic [3:0] beats;
        logic [9:0] last;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd3, 1'b0, 2'd1, 1'b1, 10'h00D, 4'd8, 10'h00C},
        '{3'd3, 1'b1, 2'd2, 1'b1, 10'h00D, 4'd8, 10'h00A},
        '{3'd2, 1'b0, 2'd3, 1'b1, 10'h3FE, 4'd4, 10'h3FD},
        '{3'd2, 1'b1, 2'd1, 1'b0, 10'h006, 4'd4, 10'h005},
        '{3'd1, 1'b0, 2'd2, 1'b1, 10'h005, 4'd2, 10'h004},
        '{3'd0, 1'b0, 2'd3, 1'b1, 10'h155, 4'd1, 10'h155},
        '{3'd1, 1'b1, 2'd1, 1'b0, 10'h200, 4'd2, 10'h201},
        '{3'd3, 1'b0, 2'd0, 1'b1, 10'h000, 4'd8, 10'h007}
    };

    function automatic logic [9:0] model(input logic [9:0] s, input int c, input int ll,
                                         input bit il, input bit pg);
        logic [9:0] m;
        m = 10'((1 << ll) - 1);
        if (pg) return 10'(s + 10'(c));
        if (il) return s ^ 10'(c);
        return (s & ~m) | (10'(s + 10'(c)) & m);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the command's edge.
    task automatic issue(input logic [1:0] op, input logic [0:0] bank, input logic [9:0] col);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank; cmd_col = col;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] len, input logic il, input logic [1:0] lat);
        mode_len = len; mode_ilv = il; mode_lat = lat;
        issue(2'b11, 1'b0, 10'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int nb, nr, first, exp_lat;
        logic [9:0] last;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_bank = 1'b0; cmd_col = '0;
        mode_len = '0; mode_ilv = 1'b0; mode_lat = 2'd1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!col_valid && !rd_valid && !mode_err, "R1 reset outputs",
            {col_valid, rd_valid, mode_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 default mode: one beat, latency one
        issue(2'b00, 1'b1, 10'h123);
        chk(col_valid && col_is_rd && col_addr == 10'h123 && col_bank == 1'b1,
            "R2 read start", col_addr, 10'h123);
        @(negedge clk);
        chk(!col_valid && rd_valid, "R1 default length and latency", {col_valid, rd_valid}, 1);
        @(negedge clk);
        chk(!rd_valid, "R10 single pulse", rd_valid, 0);

        // Table of bursts
        for (int i = 0; i < 8; i++) begin
            set_mode(VECS[i].len, VECS[i].ilv, VECS[i].lat);
            issue(VECS[i].rd ? 2'b00 : 2'b01, 1'(i), VECS[i].start);
            chk(col_valid && col_is_rd == VECS[i].rd && col_bank == 1'(i), "R2 direction and bank",
                {col_valid, col_is_rd, col_bank}, {1'b1, VECS[i].rd, 1'(i)});
            nb = 0; nr = 0; first = -1; last = '0;
            for (int s = 0; s < 12; s++) begin
                if (col_valid) begin
                    chk(col_addr == model(VECS[i].start, nb, int'(VECS[i].len), VECS[i].ilv, 1'b0),
                        VECS[i].ilv ? "R5 beat address" : "R4 beat address", col_addr,
                        model(VECS[i].start, nb, int'(VECS[i].len), VECS[i].ilv, 1'b0));
                    nb++;
                    last = col_addr;
                end
                if (rd_valid) begin
                    if (first < 0) first = s;
                    nr++;
                end
                @(negedge clk);
            end
            chk(nb == int'(VECS[i].beats), "R3 burst length", nb, VECS[i].beats);
            chk(last == VECS[i].last, VECS[i].ilv ? "R5 last address" : "R4 last address",
                last, VECS[i].last);
            chk(nr == (VECS[i].rd ? int'(VECS[i].beats) : 0), "R10 strobe count", nr,
                VECS[i].rd ? VECS[i].beats : 0);
            if (VECS[i].rd) begin
                exp_lat = (VECS[i].lat == 2'd0) ? 1 : int'(VECS[i].lat);
                chk(first == exp_lat, "R10 read latency", first, exp_lat);
            end
        end

        // R6 whole page wraps, R8 stop, R11 in-flight strobes
        set_mode(3'd4, 1'b0, 2'd2);
        issue(2'b00, 1'b1, 10'd1020);
        for (int s = 0; s < 10; s++) begin
            chk(col_valid && col_addr == 10'((1020 + s) % 1024), "R6 page address",
                col_addr, (1020 + s) % 1024);
            if (s < 9) @(negedge clk);
        end
        issue(2'b10, 1'b0, 10'h0);
        chk(!col_valid, "R8 stop", col_valid, 0);
        chk(rd_valid, "R11 in-flight strobe 1", rd_valid, 1);
        @(negedge clk);
        chk(rd_valid, "R11 in-flight strobe 2", rd_valid, 1);
        @(negedge clk);
        chk(!rd_valid, "R11 drain ends", rd_valid, 0);
        repeat (3) @(negedge clk);

        // R7 illegal mode
        set_mode(3'd5, 1'b1, 2'd1);
        chk(mode_err, "R7 error flag", mode_err, 1);
        issue(2'b00, 1'b0, 10'h00B);
        nb = 0; last = '0;
        for (int s = 0; s < 12; s++) begin
            if (col_valid) begin last = col_addr; nb++; end
            @(negedge clk);
        end
        chk(nb == 8, "R7 length eight", nb, 8);
        chk(last == 10'h00C, "R7 interleaved last", last, 10'h00C);
        set_mode(3'd3, 1'b0, 2'd1);
        chk(!mode_err, "R7 error cleared", mode_err, 0);

        // R9 interrupt by a write
        issue(2'b00, 1'b0, 10'h010);
        @(negedge clk);
        @(negedge clk);
        chk(col_addr == 10'h012, "R4 before interrupt", col_addr, 10'h012);
        issue(2'b01, 1'b1, 10'h045);
        chk(col_valid && !col_is_rd && col_bank == 1'b1 && col_addr == 10'h045,
            "R9 replaced burst", col_addr, 10'h045);
        nb = 0; last = '0;
        for (int s = 0; s < 10; s++) begin
            if (col_valid) begin last = col_addr; nb++; end
            @(negedge clk);
        end
        chk(nb == 8 && last == 10'h044, "R9 full new burst", {nb, last}, {8, 10'h044});

        // R9 back-to-back commands
        issue(2'b00, 1'b0, 10'h020);
        chk(col_addr == 10'h020, "R9 first of pair", col_addr, 10'h020);
        issue(2'b00, 1'b1, 10'h030);
        chk(col_addr == 10'h030 && col_bank == 1'b1, "R9 second of pair", col_addr, 10'h030);
        repeat (12) @(negedge clk);

        // R8 mode load ends a burst
        issue(2'b00, 1'b0, 10'h050);
        @(negedge clk);
        set_mode(3'd3, 1'b0, 2'd1);
        chk(!col_valid, "R8 mode load stops", col_valid, 0);
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule